// File: doc/BRIEF.md
# Character-Row Video Timing Generator

This block produces the raster timing for a text-mode display. A column counter walks the character clocks of one scan line. A scan counter walks the scan lines of one character row, and a row counter walks the character rows of one frame. A scan line consists of the visible characters, then the right border, then horizontal sync, then the left border. The frame height is a count of whole character rows plus a number of extra adjust scan lines. The visible picture starts at scan line 0 of column 0 of row 0.

From these counters the block drives horizontal and vertical sync, a display-enable strobe, a screen-memory address and a scan-line index. A downstream path uses the address and the index to fetch characters and look up their glyphs. That fetch and lookup take time, so display enable passes through a delay of 0, 1 or 2 clocks, selected by an input. Sync leaves the block with no added delay. A narrow/wide input selects one or two characters per clock; in wide mode the address output counts character pairs. A one-clock pulse marks each rising edge of vertical sync and serves as an interrupt source.

All timing values are static inputs. They are sampled while the block runs and must only be changed while reset is held.

Top module: `char_row_timer`

## Requirements
- R1: While `rst` is high, every output is 0. At the first clock edge after reset, the outputs show column 0, scan 0 and row 0 of the frame.
- R2: A scan line lasts `h_last`+1 clocks. `hsync` is high on exactly those lines' clocks whose column c satisfies `hs_pos` <= c < `hs_pos`+`hs_width`.
- R3: The undelayed enable is high when all of these hold: column < `h_vis`, row < `v_vis`, and the line is not an adjust line. `disp_en` equals that enable delayed by `de_delay` clocks (0, 1 or 2) relative to `hsync` and `vsync`.
- R4: A frame holds (`v_last`+1)·(`scan_last`+1)+`v_adjust` scan lines. When `v_adjust` is 0, the last scan line of row `v_last` is followed directly by row 0.
- R5: `vsync` rises in the clock whose column is 0, on scan 0 of row `vs_row`, and never on an adjust line. It stays high for `vs_lines` scan lines. A value of 0 for `vs_lines` gives no sync.
- R6: `vsync_edge` is high for exactly one clock, in the first clock that `vsync` is high.
- R7: The address counter loads `start_addr` at the top of each frame and advances by 1 on each clock whose column is < `h_vis`. At the end of each line it reloads the value it had at the start of the row. The exception is the last scan line of a row: there it keeps its advanced value, which becomes the start of the next row. The counter wraps modulo 2^AW.
- R8: With `wide` = 0, `char_addr` equals the address counter. With `wide` = 1, it equals the counter shifted left by one bit, modulo 2^AW.
- R9: `row_scan` gives the scan line within the current row, counting 0..`scan_last`. On adjust lines it counts 0..`v_adjust`-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| h_last | input | HW | Last column index of a line |
| h_vis | input | HW | Number of visible columns |
| hs_pos | input | HW | Column where horizontal sync starts |
| hs_width | input | HW | Horizontal sync width in clocks |
| scan_last | input | SW | Last scan index of a character row |
| v_last | input | RW | Last row index of a frame |
| v_vis | input | RW | Number of visible rows |
| vs_row | input | RW | Row where vertical sync starts |
| vs_lines | input | SW | Vertical sync width in scan lines |
| v_adjust | input | SW | Extra scan lines after the last row |
| start_addr | input | AW | Screen address of the frame's first character |
| wide | input | 1 | 1 selects two characters per clock |
| de_delay | input | DW | Display-enable delay in clocks, 0..DE_MAX |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| vsync_edge | output | 1 | One-clock pulse on vsync rise |
| disp_en | output | 1 | Delayed display enable |
| char_addr | output | AW | Screen-memory address |
| row_scan | output | SW | Scan line within row |

## Verification
Three events can fall in the same clock: the start of vertical sync, the frame wrap that reloads the address, and the switch from the last scan line to row 0. Setting `vs_row` to 0 makes them coincide. Setting a nonzero adjust count makes the wrap come out of an adjust line rather than a row end. With `hs_pos` at 0, the start of horizontal sync also lands in that clock.

These cases are run in directed configurations and mixed with random geometries. In every clock, each output is compared with a bench model of the counters. The bench also measures the interval between `vsync_edge` pulses and compares it with the frame length the geometry predicts.

// File: rtl/char_row_pkg.sv
`timescale 1ns/1ps
package char_row_pkg;
  // events produced by the vertical counter at a line boundary
  typedef struct packed {
    logic row_done;    // last scan line of a character row ends
    logic frame_wrap;  // last line of the frame ends
    logic vs_start;    // next line opens the vertical sync window
  } vstep_t;
endpackage

// File: rtl/crt_hcount.sv
`timescale 1ns/1ps
module crt_hcount #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_last,
  output logic [HW-1:0] col,
  output logic          line_end
);
  assign line_end = (col >= h_last);

  always_ff @(posedge clk) begin
    if (rst)           col <= '0;
    else if (line_end) col <= '0;
    else               col <= col + 1'b1;
  end
endmodule

// File: rtl/crt_vcount.sv
`timescale 1ns/1ps
module crt_vcount
  import char_row_pkg::*;
#(
  parameter int RW = 7,
  parameter int SW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic [SW-1:0] scan_last,
  input  logic [RW-1:0] v_last,
  input  logic [SW-1:0] v_adjust,
  input  logic [RW-1:0] vs_row,
  input  logic [SW-1:0] vs_lines,
  output logic [RW-1:0] row,
  output logic [SW-1:0] scan,
  output logic          in_adj,
  output logic          vs_act,
  output vstep_t        step
);
  logic [RW-1:0] nrow;
  logic [SW-1:0] nscan, adj_last, vs_left;
  logic          nadj, wrap_c;

  assign adj_last = v_adjust - 1'b1;

  always_comb begin
    nrow   = row;
    nscan  = scan + 1'b1;
    nadj   = in_adj;
    wrap_c = 1'b0;
    if (in_adj) begin
      if (scan == adj_last) begin
        nrow = '0; nscan = '0; nadj = 1'b0; wrap_c = 1'b1;
      end
    end else if (scan == scan_last) begin
      nscan = '0;
      if (row == v_last) begin
        if (v_adjust == '0) begin
          nrow = '0; wrap_c = 1'b1;
        end else begin
          nadj = 1'b1;
        end
      end else begin
        nrow = row + 1'b1;
      end
    end
  end

  assign step.row_done   = line_end && !in_adj && (scan == scan_last);
  assign step.frame_wrap = line_end && wrap_c;
  assign step.vs_start   = line_end && (nrow == vs_row) && (nscan == '0) && !nadj;
  assign vs_act          = (vs_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      row <= '0; scan <= '0; in_adj <= 1'b0; vs_left <= '0;
    end else if (line_end) begin
      row <= nrow; scan <= nscan; in_adj <= nadj;
      if (step.vs_start)       vs_left <= vs_lines;
      else if (vs_left != '0)  vs_left <= vs_left - 1'b1;
    end
  end
endmodule

// File: rtl/crt_addrgen.sv
`timescale 1ns/1ps
module crt_addrgen #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          col_vis,
  input  logic          line_end,
  input  logic          row_done,
  input  logic          frame_wrap,
  input  logic [AW-1:0] start_addr,
  output logic [AW-1:0] ma
);
  logic [AW-1:0] row_base, ma_adv;

  assign ma_adv = col_vis ? ma + 1'b1 : ma;

  always_ff @(posedge clk) begin
    if (rst || frame_wrap) begin
      ma       <= start_addr;
      row_base <= start_addr;
    end else if (line_end && row_done) begin
      ma       <= ma_adv;
      row_base <= ma_adv;
    end else if (line_end) begin
      ma       <= row_base;
    end else begin
      ma       <= ma_adv;
    end
  end
endmodule

// File: rtl/char_row_timer.sv
`timescale 1ns/1ps
module char_row_timer
  import char_row_pkg::*;
#(
  parameter int HW     = 8,
  parameter int RW     = 7,
  parameter int SW     = 5,
  parameter int AW     = 14,
  parameter int DE_MAX = 2,
  localparam int DW    = $clog2(DE_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [HW-1:0] h_last,
  input  logic [HW-1:0] h_vis,
  input  logic [HW-1:0] hs_pos,
  input  logic [HW-1:0] hs_width,
  input  logic [SW-1:0] scan_last,
  input  logic [RW-1:0] v_last,
  input  logic [RW-1:0] v_vis,
  input  logic [RW-1:0] vs_row,
  input  logic [SW-1:0] vs_lines,
  input  logic [SW-1:0] v_adjust,
  input  logic [AW-1:0] start_addr,
  input  logic          wide,
  input  logic [DW-1:0] de_delay,
  output logic          hsync,
  output logic          vsync,
  output logic          vsync_edge,
  output logic          disp_en,
  output logic [AW-1:0] char_addr,
  output logic [SW-1:0] row_scan
);
  logic [HW-1:0] col;
  logic [RW-1:0] row;
  logic [SW-1:0] scan;
  logic [AW-1:0] ma;
  logic          line_end, in_adj, vs_act, hs_c, de_c, col_vis;
  vstep_t        step;
  logic [DE_MAX:0] de_pipe;

  crt_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst(rst), .h_last(h_last), .col(col), .line_end(line_end)
  );

  crt_vcount #(.RW(RW), .SW(SW)) u_v (
    .clk(clk), .rst(rst), .line_end(line_end), .scan_last(scan_last),
    .v_last(v_last), .v_adjust(v_adjust), .vs_row(vs_row), .vs_lines(vs_lines),
    .row(row), .scan(scan), .in_adj(in_adj), .vs_act(vs_act), .step(step)
  );

  assign col_vis = (col < h_vis);

  crt_addrgen #(.AW(AW)) u_a (
    .clk(clk), .rst(rst), .col_vis(col_vis), .line_end(line_end),
    .row_done(step.row_done), .frame_wrap(step.frame_wrap),
    .start_addr(start_addr), .ma(ma)
  );

  assign hs_c = ({1'b0, col} >= {1'b0, hs_pos}) &&
                ({1'b0, col} < ({1'b0, hs_pos} + {1'b0, hs_width}));
  assign de_c = col_vis && !in_adj && (row < v_vis);

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0; vsync <= 1'b0; vsync_edge <= 1'b0;
      char_addr <= '0; row_scan <= '0; de_pipe[0] <= 1'b0;
    end else begin
      hsync      <= hs_c;
      vsync      <= vs_act;
      vsync_edge <= vs_act & ~vsync;
      char_addr  <= wide ? {ma[AW-2:0], 1'b0} : ma;
      row_scan   <= scan;
      de_pipe[0] <= de_c;
    end
  end

  // enable delay line, one stage per selectable clock of delay
  for (genvar k = 1; k <= DE_MAX; k++) begin : g_de
    always_ff @(posedge clk) begin
      if (rst) de_pipe[k] <= 1'b0;
      else     de_pipe[k] <= de_pipe[k-1];
    end
  end

  assign disp_en = (de_delay > DW'(DE_MAX)) ? de_pipe[DE_MAX] : de_pipe[de_delay];
endmodule

// File: rtl/char_row_timer_chk.sv
`timescale 1ns/1ps
module char_row_timer_chk #(
  parameter int HW = 8,
  parameter int RW = 7,
  parameter int SW = 5,
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          vsync,
  input logic          vsync_edge,
  input logic [HW-1:0] col,
  input logic [HW-1:0] h_last,
  input logic [SW-1:0] scan,
  input logic [SW-1:0] scan_last,
  input logic [RW-1:0] row,
  input logic [RW-1:0] vs_row,
  input logic          in_adj,
  input logic          vs_act,
  input logic          frame_wrap,
  input logic [AW-1:0] ma,
  input logic [AW-1:0] start_addr
);
  p_col_bound_r2: assert property (@(posedge clk) disable iff (rst)
    col <= h_last);

  p_vs_start_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_act) |-> (col == '0 && scan == '0 && row == vs_row && !in_adj));

  p_edge_single_r6: assert property (@(posedge clk) disable iff (rst)
    vsync_edge |=> !vsync_edge);

  p_edge_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
    vsync_edge == $rose(vsync));

  p_wrap_addr_r7: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> (ma == start_addr));

  p_scan_bound_r9: assert property (@(posedge clk) disable iff (rst)
    !in_adj |-> (scan <= scan_last));
endmodule

bind char_row_timer char_row_timer_chk #(.HW(HW), .RW(RW), .SW(SW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .vsync(vsync), .vsync_edge(vsync_edge),
  .col(col), .h_last(h_last), .scan(scan), .scan_last(scan_last),
  .row(row), .vs_row(vs_row), .in_adj(in_adj), .vs_act(vs_act),
  .frame_wrap(step.frame_wrap), .ma(ma), .start_addr(start_addr)
);

// File: tb/tb_char_row_timer.sv
`timescale 1ns/1ps
module tb_char_row_timer;
  localparam int HW = 8, RW = 7, SW = 5, AW = 14, DE_MAX = 2, DW = 2;
  localparam int AMASK = (1 << AW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic [HW-1:0] h_last, h_vis, hs_pos, hs_width;
  logic [SW-1:0] scan_last, vs_lines, v_adjust;
  logic [RW-1:0] v_last, v_vis, vs_row;
  logic [AW-1:0] start_addr;
  logic wide;
  logic [DW-1:0] de_delay;
  logic hsync, vsync, vsync_edge, disp_en;
  logic [AW-1:0] char_addr;
  logic [SW-1:0] row_scan;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  char_row_timer #(.HW(HW), .RW(RW), .SW(SW), .AW(AW), .DE_MAX(DE_MAX)) dut (.*);

  // bench model of the counters
  int mcol, mscan, mrow, madj, mvs, mma, mbase;
  bit prev_vs;
  bit [DE_MAX:0] hist;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int frame_clocks();
    return (int'(h_last) + 1) * ((int'(v_last) + 1) * (int'(scan_last) + 1) + int'(v_adjust));
  endfunction

  task automatic model_step();
    int nrow, nscan, nadj;
    bit lend, rdone, wrap, vis;
    lend  = (mcol >= int'(h_last));
    vis   = (mcol < int'(h_vis));
    rdone = lend && !madj && (mscan == int'(scan_last));
    nrow = mrow; nscan = mscan + 1; nadj = madj; wrap = 0;
    if (madj != 0) begin
      if (mscan == int'(v_adjust) - 1) begin nrow = 0; nscan = 0; nadj = 0; wrap = 1; end
    end else if (mscan == int'(scan_last)) begin
      nscan = 0;
      if (mrow == int'(v_last)) begin
        if (v_adjust == 0) begin nrow = 0; wrap = 1; end else nadj = 1;
      end else nrow = mrow + 1;
    end
    // address
    if (lend && wrap) begin mma = start_addr; mbase = start_addr; end
    else if (lend && rdone) begin mma = (mma + (vis ? 1 : 0)) & AMASK; mbase = mma; end
    else if (lend) mma = mbase;
    else if (vis) mma = (mma + 1) & AMASK;
    if (lend) begin
      if (nrow == int'(vs_row) && nscan == 0 && nadj == 0) mvs = vs_lines;
      else if (mvs != 0) mvs--;
      mrow = nrow; mscan = nscan; madj = nadj; mcol = 0;
    end else mcol++;
  endtask

  task automatic run_cfg(input int cycles, input string tag);
    int since_edge; bit seen_edge;
    bit e_hs, e_vs, e_edge, e_de;
    int e_addr;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs held at zero during reset
    chk("R1 reset outputs", {hsync, vsync, vsync_edge, disp_en, |char_addr, |row_scan}, 0);
    rst = 1'b0;
    mcol = 0; mscan = 0; mrow = 0; madj = 0; mvs = 0;
    mma = start_addr; mbase = start_addr; prev_vs = 0; hist = '0;
    since_edge = 0; seen_edge = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      e_hs   = (mcol >= int'(hs_pos)) && (mcol < int'(hs_pos) + int'(hs_width));
      e_vs   = (mvs != 0);
      e_edge = e_vs && !prev_vs;
      prev_vs = e_vs;
      hist   = {hist[DE_MAX-1:0], (mcol < int'(h_vis)) && madj == 0 && (mrow < int'(v_vis))};
      e_de   = hist[de_delay];
      e_addr = wide ? ((mma << 1) & AMASK) : mma;
      if (c == 0) chk("R1 first frame position", {int'(row_scan), int'(char_addr)},
                      {32'd0, e_addr});
      chk("R2 hsync", hsync, e_hs);
      chk("R5 vsync", vsync, e_vs);
      chk("R6 vsync_edge", vsync_edge, e_edge);
      chk("R3 disp_en", disp_en, e_de);
      chk(wide ? "R8 wide address" : "R7 address", char_addr, e_addr);
      chk("R9 row_scan", row_scan, mscan);
      since_edge++;
      if (vsync_edge) begin
        // R4: edge-to-edge spacing equals frame length
        if (seen_edge) chk("R4 frame length", since_edge, frame_clocks());
        seen_edge = 1; since_edge = 0;
      end
      model_step();
    end
    if (vs_lines != 0 && int'(vs_row) <= int'(v_last))
      chk({"R5 sync seen in ", tag}, seen_edge, 1);
  endtask

  initial begin
    void'($urandom(32'd4032));
    // directed: standard text geometry
    h_last = 63; h_vis = 40; hs_pos = 48; hs_width = 4;
    scan_last = 7; v_last = 49; v_vis = 25; vs_row = 37; vs_lines = 16; v_adjust = 0;
    start_addr = 0; wide = 0; de_delay = 1;
    run_cfg(46000, "default");
    // directed: sync at row 0 meets frame wrap, hsync at column 0, adjust lines, wide, address wrap
    h_last = 11; h_vis = 6; hs_pos = 0; hs_width = 3;
    scan_last = 2; v_last = 3; v_vis = 3; vs_row = 0; vs_lines = 2; v_adjust = 2;
    start_addr = AW'(AMASK - 2); wide = 1; de_delay = 2;
    run_cfg(3000, "row0 adjust");
    // directed: adjust zero, sync at row 0, no enable delay
    v_adjust = 0; wide = 0; de_delay = 0; scan_last = 0;
    run_cfg(1500, "row0 noadj");
    // constrained random geometries
    for (int k = 0; k < 20; k++) begin
      int ht, hd, vt;
      ht = 8 + $urandom % 16; hd = 1 + $urandom % ht; vt = 1 + $urandom % 6;
      h_last = HW'(ht); h_vis = HW'(hd);
      hs_pos = HW'(hd + $urandom % (ht - hd + 1)); hs_width = HW'(1 + $urandom % 4);
      scan_last = SW'($urandom % 5); v_last = RW'(vt);
      v_vis = RW'(1 + $urandom % (vt + 1)); vs_row = RW'($urandom % (vt + 1));
      vs_lines = SW'(1 + $urandom % (int'(scan_last) + 1)); v_adjust = SW'($urandom % 4);
      start_addr = AW'($urandom); wide = 1'($urandom); de_delay = DW'(1 + $urandom % 2);
      run_cfg(frame_clocks() * 2 + frame_clocks() / 2 + 10, "random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule